// File: doc/BRIEF.md
# Coprocessor Instruction Push Router

This block sits between five scalar cores and a coprocessor that runs three instruction threads. Each core drives its own store request port (valid, address, data word), and the port index identifies the source core: index 0 is the control core, indices 1, 2 and 3 are the thread cores for threads 0, 1 and 2, and index 4 is the data-movement core. A store that hits one of three push addresses is written as an opcode into one of three per-thread instruction FIFOs. The target depends on both the address and the issuing core. Every other store, and every store from the data-movement core, leaves on a single downstream port unchanged.

There is no status register. A core whose target FIFO is full sees its ready held low until a slot frees up. A thread core that stores to a push address reserved for the control core is locked up. Each core has a two-state machine with the states CORE_RUN and CORE_HUNG. The transition CORE_RUN to CORE_HUNG, named "illegal store", fires on a valid request that decodes as illegal. CORE_HUNG has no exit except reset. While a core is hung its ready stays low and its error flag stays high. The coprocessor side pops each FIFO through a valid/pop pair.

Top module: `instr_push_router`

## Requirements
- R1: A store from core 0 to address 0xFFE40000, 0xFFE50000 or 0xFFE60000 is accepted in the same cycle (ready high) and writes its data word into FIFO 0, 1 or 2 respectively.
- R2: A store from core k+1 (k = 0, 1, 2) to 0xFFE40000 writes its data word into FIFO k.
- R3: A store from core 1, 2 or 3 to 0xFFE50000 or 0xFFE60000 writes no FIFO and never reaches the downstream port. From the next cycle that core's bit in `core_hung` is 1 and its ready stays 0 for every later request, until reset.
- R4: A store from core 4 never writes a FIFO, whatever its address. It leaves on the downstream port with `ds_src` = 4.
- R5: A store to any address other than the three push addresses appears on the downstream port in the same cycle, with its address, data and source index. When several cores pass through at once, the lowest index wins. The store is accepted only when `ds_ready` is 1.
- R6: Each accepted push adds exactly one entry. Each FIFO returns entries in push order. `fifo_valid[t]` is 1 exactly when FIFO t holds an entry, and `fifo_data[t]` shows the oldest entry.
- R7: A FIFO holds DEPTH entries. While it is full, a store aimed at it sees ready 0, and nothing is written. A pop in that cycle lets the store through on the following cycle.
- R8: When several cores aim at the same FIFO in one cycle, the lowest core index is accepted and the others see ready 0.
- R9: After reset all FIFOs are empty, `core_hung` is 0, `ds_valid` is 0 and no ready is high without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 5 | Store request per core |
| req_addr | input | 5x32 | Store address per core |
| req_data | input | 5x32 | Store data per core |
| req_ready | output | 5 | Store accepted this cycle |
| core_hung | output | 5 | Sticky lock-up flag per core |
| ds_valid | output | 1 | Passed-through store valid |
| ds_src | output | 3 | Source core of the passed-through store |
| ds_addr | output | 32 | Passed-through address |
| ds_data | output | 32 | Passed-through data |
| ds_ready | input | 1 | Downstream accepts the store |
| fifo_valid | output | 3 | Per-thread FIFO not empty |
| fifo_data | output | 3x32 | Per-thread oldest opcode |
| fifo_pop | input | 3 | Per-thread pop request |

## Verification
The bench builds the router with DEPTH = 4. With that depth, the full-FIFO stall, the pop that releases it, and the wrap of the read and write pointers are all reached within a few cycles. The bench sweeps every pairing of the five cores with the three push addresses and one unrelated address. It resets before each pairing and derives the expected push, hang or pass-through outcome from the core index and the address. It then checks same-cycle contention, both on a shared FIFO and on the downstream port.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
    localparam int NCORE   = 5;
    localparam int NTHR    = 3;
    localparam int SRC_W   = $clog2(NCORE);
    localparam int CORE_CTRL = 0;
    localparam int CORE_DM   = 4;

    typedef enum logic [1:0] {
        ACT_PASS = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_HANG = 2'd2
    } act_e;

    typedef struct packed {
        act_e       act;
        logic [1:0] thr;
    } route_t;

    typedef enum logic {
        CORE_RUN  = 1'b0,
        CORE_HUNG = 1'b1
    } core_st_e;
endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
    import ipr_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          CORE_ID = 0,
    parameter logic [31:0] BASE0   = 32'hFFE4_0000,
    parameter logic [31:0] BASE1   = 32'hFFE5_0000,
    parameter logic [31:0] BASE2   = 32'hFFE6_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output route_t            route
);
    logic [2:0] hit;

    always_comb begin
        hit[0] = (addr == ADDR_W'(BASE0));
        hit[1] = (addr == ADDR_W'(BASE1));
        hit[2] = (addr == ADDR_W'(BASE2));
        route.act = ACT_PASS;
        route.thr = 2'd0;
        if (CORE_ID == CORE_DM) begin
            route.act = ACT_PASS;
        end else if (CORE_ID == CORE_CTRL) begin
            if (hit[0]) begin
                route.act = ACT_PUSH;
                route.thr = 2'd0;
            end else if (hit[1]) begin
                route.act = ACT_PUSH;
                route.thr = 2'd1;
            end else if (hit[2]) begin
                route.act = ACT_PUSH;
                route.thr = 2'd2;
            end
        end else begin
            if (hit[0]) begin
                route.act = ACT_PUSH;
                route.thr = 2'(CORE_ID - 1);
            end else if (hit[1] || hit[2]) begin
                route.act = ACT_HANG;
            end
        end
    end
endmodule

// File: rtl/ipr_core_fsm.sv
module ipr_core_fsm
    import ipr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic illegal,
    output logic hung
);
    core_st_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CORE_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            CORE_RUN:  st_nx = (req_valid && illegal) ? CORE_HUNG : CORE_RUN;
            CORE_HUNG: st_nx = CORE_HUNG;
        endcase
    end

    always_comb begin
        hung = (st == CORE_HUNG);
    end

    a_r3_hang_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hung |=> hung);
    a_r3_hang_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && illegal) |=> hung);
endmodule

// File: rtl/ipr_fifo.sv
module ipr_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic          full,
    output logic          empty,
    output logic [DW-1:0] rd_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= bump(wp);
            if (rd_en) rp <= bump(rp);
            case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_comb begin
        full    = (cnt == CW'(DEPTH));
        empty   = (cnt == '0);
        rd_data = mem[rp];
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    a_r6_one_entry_per_push: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/instr_push_router.sv
module instr_push_router
    import ipr_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int          DATA_W = 32,
    parameter int          DEPTH  = 32,
    parameter logic [31:0] BASE0  = 32'hFFE4_0000,
    parameter logic [31:0] BASE1  = 32'hFFE5_0000,
    parameter logic [31:0] BASE2  = 32'hFFE6_0000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCORE-1:0]             req_valid,
    input  logic [NCORE-1:0][ADDR_W-1:0] req_addr,
    input  logic [NCORE-1:0][DATA_W-1:0] req_data,
    output logic [NCORE-1:0]             req_ready,
    output logic [NCORE-1:0]             core_hung,
    output logic                         ds_valid,
    output logic [SRC_W-1:0]             ds_src,
    output logic [ADDR_W-1:0]            ds_addr,
    output logic [DATA_W-1:0]            ds_data,
    input  logic                         ds_ready,
    output logic [NTHR-1:0]              fifo_valid,
    output logic [NTHR-1:0][DATA_W-1:0]  fifo_data,
    input  logic [NTHR-1:0]              fifo_pop
);
    route_t [NCORE-1:0]             route;
    logic   [NCORE-1:0]             illegal;
    logic   [NCORE-1:0]             want_push, want_pass, ds_gnt;
    logic   [NTHR-1:0][NCORE-1:0]   push_gnt;
    logic   [NTHR-1:0]              wr_en, rd_en, full, empty;
    logic   [NTHR-1:0][DATA_W-1:0]  wr_data;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        ipr_decode #(
            .ADDR_W(ADDR_W), .CORE_ID(c),
            .BASE0(BASE0), .BASE1(BASE1), .BASE2(BASE2)
        ) u_dec (
            .addr  (req_addr[c]),
            .route (route[c])
        );

        ipr_core_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[c]),
            .illegal   (illegal[c]),
            .hung      (core_hung[c])
        );

        a_r3_hung_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
            core_hung[c] |-> !req_ready[c]);
    end

    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            illegal[c]   = (route[c].act == ACT_HANG);
            want_push[c] = req_valid[c] && !core_hung[c] && (route[c].act == ACT_PUSH);
            want_pass[c] = req_valid[c] && !core_hung[c] && (route[c].act == ACT_PASS);
        end
    end

    // fixed priority per thread: lowest core index wins
    always_comb begin
        push_gnt = '0;
        wr_en    = '0;
        wr_data  = '0;
        for (int t = 0; t < NTHR; t++) begin
            for (int c = NCORE - 1; c >= 0; c--) begin
                if (want_push[c] && (route[c].thr == 2'(t))) begin
                    push_gnt[t]    = '0;
                    push_gnt[t][c] = 1'b1;
                    wr_data[t]     = req_data[c];
                end
            end
            wr_en[t] = (|push_gnt[t]) && !full[t];
        end
    end

    // downstream pass-through, lowest index wins
    always_comb begin
        ds_gnt  = '0;
        ds_src  = '0;
        ds_addr = '0;
        ds_data = '0;
        for (int c = NCORE - 1; c >= 0; c--) begin
            if (want_pass[c]) begin
                ds_gnt    = '0;
                ds_gnt[c] = 1'b1;
                ds_src    = SRC_W'(c);
                ds_addr   = req_addr[c];
                ds_data   = req_data[c];
            end
        end
        ds_valid = |ds_gnt;
    end

    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            req_ready[c] = ds_gnt[c] && ds_ready;
            for (int t = 0; t < NTHR; t++) begin
                if (push_gnt[t][c] && !full[t]) req_ready[c] = 1'b1;
            end
        end
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        assign rd_en[t]      = fifo_pop[t] && !empty[t];
        assign fifo_valid[t] = !empty[t];

        ipr_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[t]),
            .wr_data (wr_data[t]),
            .rd_en   (rd_en[t]),
            .full    (full[t]),
            .empty   (empty[t]),
            .rd_data (fifo_data[t])
        );

        a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(push_gnt[t]));
        a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            full[t] |-> !wr_en[t]);
    end

    a_r4_dm_never_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready[CORE_DM] |-> (ds_valid && ds_src == SRC_W'(CORE_DM) && ds_ready));
    a_r5_ds_single: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(req_ready & ds_gnt) <= 1);
endmodule

// File: tb/instr_push_router_bench.sv
`timescale 1ns/1ps
module instr_push_router_bench;
    import ipr_pkg::*;
    localparam int DEP = 4;
    localparam logic [31:0] A0 = 32'hFFE4_0000;
    localparam logic [31:0] A1 = 32'hFFE5_0000;
    localparam logic [31:0] A2 = 32'hFFE6_0000;
    localparam logic [31:0] AX = 32'hFFE7_0000;

    logic clk = 1'b0;
    logic rst_n;
    logic [4:0]       req_valid;
    logic [4:0][31:0] req_addr;
    logic [4:0][31:0] req_data;
    logic [4:0]       req_ready;
    logic [4:0]       core_hung;
    logic             ds_valid;
    logic [2:0]       ds_src;
    logic [31:0]      ds_addr, ds_data;
    logic             ds_ready;
    logic [2:0]       fifo_valid;
    logic [2:0][31:0] fifo_data;
    logic [2:0]       fifo_pop;

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    instr_push_router #(.DEPTH(DEP)) u_instr_push_router (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready), .core_hung(core_hung),
        .ds_valid(ds_valid), .ds_src(ds_src), .ds_addr(ds_addr),
        .ds_data(ds_data), .ds_ready(ds_ready),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_req();
        req_valid = '0;
        req_addr  = '0;
        req_data  = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clear_req();
        fifo_pop = '0;
        ds_ready = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    function automatic logic [31:0] addr_of(input int a);
        case (a)
            0: return A0;
            1: return A1;
            2: return A2;
            default: return AX;
        endcase
    endfunction

    // called at a negedge with no requests; pops one entry and checks it
    task automatic pop_chk(input string tag, input int t, input logic [31:0] exp);
        #1;
        chk({tag, " valid"}, 32'(fifo_valid[t]), 32'd1);
        chk({tag, " data"}, fifo_data[t], exp);
        fifo_pop[t] = 1'b1;
        @(posedge clk);
        @(negedge clk) fifo_pop[t] = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk("R9 hung after reset", 32'(core_hung), 32'd0);
        chk("R9 fifo empty after reset", 32'(fifo_valid), 32'd0);
        chk("R9 ds idle after reset", 32'(ds_valid), 32'd0);
        chk("R9 no ready after reset", 32'(req_ready), 32'd0);

        // sweep: every core against every address class
        for (int c = 0; c < 5; c++) begin
            for (int a = 0; a < 4; a++) begin
                int kind;   // 0 pass, 1 push, 2 hang
                int t;
                logic [31:0] d;
                t = 0;
                if (c == 4 || a == 3) kind = 0;
                else if (c == 0) begin kind = 1; t = a; end
                else if (a == 0) begin kind = 1; t = c - 1; end
                else kind = 2;
                d = {8'(c), 8'(a), 16'hBEEF};
                do_reset();
                @(negedge clk);
                req_valid[c] = 1'b1;
                req_addr[c]  = addr_of(a);
                req_data[c]  = d;
                #1;
                if (kind == 0) begin
                    chk("R5 pass ready", 32'(req_ready), 32'(5'b1 << c));
                    chk("R5 ds valid", 32'(ds_valid), 32'd1);
                    chk("R4 ds src", 32'(ds_src), 32'(c));
                    chk("R5 ds addr", ds_addr, addr_of(a));
                    chk("R5 ds data", ds_data, d);
                    @(posedge clk);
                    @(negedge clk) clear_req();
                    #1;
                    chk("R4 pass leaves fifos empty", 32'(fifo_valid), 32'd0);
                end else if (kind == 1) begin
                    chk(c == 0 ? "R1 push ready" : "R2 push ready", 32'(req_ready), 32'(5'b1 << c));
                    chk("R1 no ds on push", 32'(ds_valid), 32'd0);
                    @(posedge clk);
                    @(negedge clk) clear_req();
                    #1;
                    chk(c == 0 ? "R1 target fifo" : "R2 target fifo", 32'(fifo_valid), 32'(3'b1 << t));
                    pop_chk("R6 pushed word", t, d);
                    #1;
                    chk("R6 one entry per store", 32'(fifo_valid), 32'd0);
                end else begin
                    chk("R3 illegal not ready", 32'(req_ready), 32'd0);
                    chk("R3 illegal no ds", 32'(ds_valid), 32'd0);
                    @(posedge clk);
                    @(negedge clk);
                    req_addr[c] = A0;
                    #1;
                    chk("R3 hung flag", 32'(core_hung), 32'(5'b1 << c));
                    repeat (3) @(posedge clk);
                    #1;
                    chk("R3 hung ignores legal store", 32'(req_ready), 32'd0);
                    chk("R3 hung no fifo write", 32'(fifo_valid), 32'd0);
                    chk("R3 hung sticky", 32'(core_hung), 32'(5'b1 << c));
                    do_reset();
                    #1;
                    chk("R9 reset clears hung", 32'(core_hung), 32'd0);
                end
            end
        end

        // full FIFO stall and release (R7)
        do_reset();
        for (int i = 0; i < DEP; i++) begin
            @(negedge clk);
            req_valid[0] = 1'b1;
            req_addr[0]  = A1;
            req_data[0]  = 32'(100 + i);
            #1;
            chk("R7 fill ready", 32'(req_ready[0]), 32'd1);
            @(posedge clk);
        end
        @(negedge clk) req_data[0] = 32'd200;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R7 stalled while full", 32'(req_ready[0]), 32'd0);
            chk("R7 head unchanged", fifo_data[1], 32'd100);
            @(posedge clk);
            @(negedge clk);
        end
        fifo_pop[1] = 1'b1;
        #1;
        chk("R7 still stalled in pop cycle", 32'(req_ready[0]), 32'd0);
        @(posedge clk);
        @(negedge clk) fifo_pop[1] = 1'b0;
        #1;
        chk("R7 released after pop", 32'(req_ready[0]), 32'd1);
        @(posedge clk);
        @(negedge clk) clear_req();
        for (int i = 1; i < DEP; i++) pop_chk("R6 order after stall", 1, 32'(100 + i));
        pop_chk("R7 stalled word kept", 1, 32'd200);
        #1;
        chk("R6 drained", 32'(fifo_valid), 32'd0);

        // same-FIFO contention (R8)
        do_reset();
        @(negedge clk);
        req_valid = 5'b00101;
        req_addr[0] = A1; req_data[0] = 32'hA;
        req_addr[2] = A0; req_data[2] = 32'hB;
        #1;
        chk("R8 lowest index wins", 32'(req_ready), 32'b00001);
        @(posedge clk);
        @(negedge clk) req_valid[0] = 1'b0;
        #1;
        chk("R8 loser proceeds", 32'(req_ready), 32'b00100);
        @(posedge clk);
        @(negedge clk) clear_req();
        pop_chk("R8 winner first", 1, 32'hA);
        pop_chk("R8 loser second", 1, 32'hB);

        // three thread cores in parallel (R2)
        @(negedge clk);
        req_valid = 5'b01110;
        for (int c = 1; c < 4; c++) begin
            req_addr[c] = A0;
            req_data[c] = 32'(c * 17);
        end
        #1;
        chk("R2 parallel ready", 32'(req_ready), 32'b01110);
        @(posedge clk);
        @(negedge clk) clear_req();
        for (int t = 0; t < 3; t++) pop_chk("R2 parallel data", t, 32'((t + 1) * 17));

        // downstream contention and backpressure (R5)
        @(negedge clk);
        req_valid = 5'b10010;
        req_addr[1] = AX; req_data[1] = 32'h11;
        req_addr[4] = A0; req_data[4] = 32'h44;
        #1;
        chk("R5 ds lowest index", 32'(ds_src), 32'd1);
        chk("R5 ds ready split", 32'(req_ready), 32'b00010);
        ds_ready = 1'b0;
        #1;
        chk("R5 ds backpressure", 32'(req_ready), 32'd0);
        ds_ready = 1'b1;
        req_valid[1] = 1'b0;
        #1;
        chk("R4 dm on ds", 32'(ds_src), 32'd4);
        chk("R4 dm ready", 32'(req_ready), 32'b10000);
        @(posedge clk);
        @(negedge clk) clear_req();
        #1;
        chk("R4 dm no push", 32'(fifo_valid), 32'd0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule